// File: doc/BRIEF.md
# Escaped-Byte Frame Deframer

This block sits behind a serial receiver and turns a raw byte stream into payload bytes. Frames are bracketed by a delimiter byte (0x02), and an escape byte (0x10) marks the byte that follows it as literal data. The deframer removes delimiters and escapes and forwards only the payload. It reports the end of each non-empty frame with a single-cycle pulse and shows whether it is currently inside a frame.

Bytes enter through a valid/ready handshake and leave through another valid/ready handshake that is one register deep. Across bytes, the decoder keeps three pieces of state: an escape-pending flag, an in-frame flag and a wrapping 8-bit payload length. A delimiter that arrives while the length is zero is treated as a new start after lost sync, so empty frames are never reported. Bytes that arrive outside a frame are thrown away.

Top module: `stuffed_frame_decoder`

## Requirements
- R1: Inside a frame, a byte other than 0x02 or 0x10 that arrives with no escape pending is forwarded unchanged and in order. It appears on outByte with outValid high in the cycle after it is accepted.
- R2: A 0x10 that arrives with no escape pending is never forwarded and sets escape-pending. Inside a frame, the next 0x10 or 0x02 is then forwarded as a literal byte and clears escape-pending.
- R3: A 0x02 that arrives outside a frame with no escape pending is not forwarded. It raises inFrame in the cycle after it is accepted.
- R4: A 0x02 that arrives inside a frame with no escape pending, after at least one payload byte, is not forwarded. It clears inFrame and drives outEof high for exactly one cycle, the cycle after the 0x02 is accepted.
- R5: A 0x02 that arrives inside a frame with no escape pending and a payload length of zero is not forwarded. It produces no outEof, and inFrame stays high.
- R6: Outside a frame, every byte is dropped. A byte other than 0x02 or 0x10 leaves escape-pending unchanged. An escaped 0x10 keeps escape-pending set. An escaped 0x02 clears escape-pending and does not open a frame.
- R7: While outValid is high and outReady is low, outByte holds its value and inReady is low, so no byte is lost. When outReady returns high, a new byte can be accepted in the same cycle as the held byte is taken.
- R8: A synchronous reset clears escape-pending, inFrame, the payload length, outValid and outEof.
- R9: The payload length counter is 8 bits wide and wraps. After exactly 256 payload bytes it reads zero, so an unescaped 0x02 at that point is treated as a resync and does not end the frame.
- R10: Inside a frame, a byte other than 0x02 or 0x10 that arrives with escape pending is forwarded and leaves escape-pending set. A following 0x02 is therefore forwarded as a literal byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input byte is valid |
| inReady | output | 1 | Decoder can accept an input byte |
| inByte | input | 8 | Raw received byte |
| outValid | output | 1 | Payload byte is valid |
| outReady | input | 1 | Downstream accepts the payload byte |
| outByte | output | 8 | Payload byte |
| outEof | output | 1 | One-cycle pulse when a frame closes |
| inFrame | output | 1 | High while inside a frame |

## Verification
The bench targets the escape sequences that cross the state flags:
- An escaped delimiter outside a frame. A design that decodes this wrongly opens a phantom frame.
- A double escape outside a frame. A design that clears the flag here lets the next delimiter open a frame.
- An escape followed by an ordinary byte. A design that clears the flag here ends the frame one byte early.

It also checks a back-to-back delimiter pair, which must not produce an empty-frame pulse. A 256-byte frame checks that the wrap to zero makes a design take the closing delimiter as a resync. Output backpressure checks that a byte held in the output register is neither overwritten nor duplicated.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  // Strobes from the control to the datapath, valid for one accepted byte.
  typedef struct packed {
    logic emit;    // load byte into output register and count it
    logic lenClr;  // clear payload length
    logic eof;     // frame closed
  } sfd_strobe_t;
endpackage

// File: rtl/sfd_ctrl.sv
module sfd_ctrl
  import sfd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] DELIM = 8'h02,
  parameter logic [DATA_W-1:0] ESC   = 8'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [DATA_W-1:0] inByte,
  input  logic              lenZero,
  output sfd_strobe_t       strb,
  output logic              inFrame
);
  logic escPend, escPendNext, inFrameNext;
  logic isDelim, isEsc;

  assign isDelim = (inByte == DELIM);
  assign isEsc   = (inByte == ESC);

  always_comb begin
    strb        = '0;
    escPendNext = escPend;
    inFrameNext = inFrame;
    if (accept) begin
      if (isEsc) begin
        if (!escPend) begin
          escPendNext = 1'b1;
        end else if (inFrame) begin
          strb.emit   = 1'b1;
          escPendNext = 1'b0;
        end
        // escaped escape outside a frame: dropped, flag stays set
      end else if (isDelim) begin
        if (escPend) begin
          escPendNext = 1'b0;
          if (inFrame) strb.emit = 1'b1;
        end else if (!inFrame) begin
          inFrameNext = 1'b1;
        end else if (!lenZero) begin
          inFrameNext = 1'b0;
          strb.lenClr = 1'b1;
          strb.eof    = 1'b1;
        end
        // zero-length delimiter inside a frame: resync, stay in frame
      end else if (inFrame) begin
        strb.emit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      escPend <= 1'b0;
      inFrame <= 1'b0;
    end else begin
      escPend <= escPendNext;
      inFrame <= inFrameNext;
    end
  end

  // R8: state is clear in the first cycle after reset
  a_r8_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!inFrame && !escPend));
endmodule

// File: rtl/sfd_datapath.sv
module sfd_datapath
  import sfd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  sfd_strobe_t       strb,
  input  logic [DATA_W-1:0] inByte,
  input  logic              outReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outByte,
  output logic              outEof,
  output logic              lenZero
);
  logic [LEN_W-1:0] lenCnt;

  assign lenZero = (lenCnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outByte  <= '0;
    end else if (strb.emit) begin
      outValid <= 1'b1;
      outByte  <= inByte;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lenCnt <= '0;
      outEof <= 1'b0;
    end else begin
      outEof <= strb.eof;
      if (strb.lenClr)    lenCnt <= '0;
      else if (strb.emit) lenCnt <= lenCnt + 1'b1;
    end
  end

  // R7: a held byte stays put until taken
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outByte)));
  // R4: end-of-frame is a single-cycle pulse
  a_r4_eof_pulse: assert property (@(posedge clk) disable iff (rst)
    outEof |=> !outEof);
  // R9: a cleared length reads zero next cycle
  a_r9_len_cleared: assert property (@(posedge clk) disable iff (rst)
    $past(strb.lenClr) |-> lenZero);
endmodule

// File: rtl/stuffed_frame_decoder.sv
module stuffed_frame_decoder
  import sfd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8,
  parameter logic [DATA_W-1:0] DELIM = 8'h02,
  parameter logic [DATA_W-1:0] ESC   = 8'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inByte,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outByte,
  output logic              outEof,
  output logic              inFrame
);
  sfd_strobe_t strb;
  logic        accept, lenZero;

  assign inReady = !outValid || outReady;
  assign accept  = inValid && inReady;

  sfd_ctrl #(.DATA_W(DATA_W), .DELIM(DELIM), .ESC(ESC)) u_ctrl (
    .clk(clk), .rst(rst), .accept(accept), .inByte(inByte),
    .lenZero(lenZero), .strb(strb), .inFrame(inFrame)
  );

  sfd_datapath #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .inByte(inByte),
    .outReady(outReady), .outValid(outValid), .outByte(outByte),
    .outEof(outEof), .lenZero(lenZero)
  );

  // R4: a frame end pulse follows leaving a frame
  a_r4_eof_leaves_frame: assert property (@(posedge clk) disable iff (rst)
    outEof |-> (!inFrame && $past(inFrame)));
endmodule

// File: tb/stuffed_frame_decoder_tb.sv
module stuffed_frame_decoder_tb;
  logic clk = 1'b0;
  logic rst, inValid, inReady, outValid, outReady, outEof, inFrame;
  logic [7:0] inByte, outByte;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  stuffed_frame_decoder u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inByte(inByte), .outValid(outValid), .outReady(outReady),
    .outByte(outByte), .outEof(outEof), .inFrame(inFrame)
  );

  // {byte, expect emit, expect eof, expect inFrame after, requirement number}
  localparam int NV = 22;
  localparam logic [14:0] VEC [NV] = '{
    {8'h41, 3'b000, 4'd6},   // R6 stray byte dropped
    {8'h10, 3'b000, 4'd6},   // R6 escape outside
    {8'h02, 3'b000, 4'd6},   // R6 escaped delimiter does not open
    {8'h02, 3'b001, 4'd3},   // R3 open
    {8'h02, 3'b001, 4'd5},   // R5 resync
    {8'h55, 3'b101, 4'd1},   // R1 payload
    {8'h10, 3'b001, 4'd2},   // R2 escape hidden
    {8'h02, 3'b101, 4'd2},   // R2 literal delimiter
    {8'h10, 3'b001, 4'd2},
    {8'h10, 3'b101, 4'd2},   // R2 literal escape
    {8'h02, 3'b010, 4'd4},   // R4 close
    {8'h10, 3'b000, 4'd6},
    {8'h10, 3'b000, 4'd6},   // R6 escape stays pending
    {8'h02, 3'b000, 4'd6},   // R6 cleared, no open
    {8'h02, 3'b001, 4'd3},   // R3 open
    {8'h10, 3'b001, 4'd10},
    {8'h33, 3'b101, 4'd10},  // R10 emitted, escape kept
    {8'h02, 3'b101, 4'd10},  // R10 literal delimiter
    {8'h02, 3'b010, 4'd4},   // R4 close
    {8'h02, 3'b001, 4'd3},
    {8'h7F, 3'b101, 4'd1},
    {8'h02, 3'b010, 4'd4}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge after one accept edge.
  task automatic step(input logic [7:0] b);
    inValid = 1'b1;
    inByte  = b;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; inValid = 1'b0; inByte = 8'h00; outReady = 1'b1;
    @(negedge clk);
    doReset();
    // R8 reset state
    chk("R8", "outValid", outValid, 0);
    chk("R8", "inFrame", inFrame, 0);
    chk("R8", "outEof", outEof, 0);
    chk("R8", "inReady", inReady, 1);

    for (int i = 0; i < NV; i++) begin
      string rq;
      step(VEC[i][14:7]);
      rq = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
      chk(rq, "outValid", outValid, VEC[i][6]);
      if (VEC[i][6]) chk(rq, "outByte", outByte, VEC[i][14:7]);
      chk(rq, "outEof", outEof, VEC[i][5]);
      chk(rq, "inFrame", inFrame, VEC[i][4]);
    end

    // R8 reset mid-frame with escape pending: next 0x02 must open, not emit
    step(8'h02); step(8'h10);
    doReset();
    chk("R8", "inFrame after reset", inFrame, 0);
    step(8'h02);
    chk("R8", "delimiter opens after reset", inFrame, 1);
    chk("R8", "no emit", outValid, 0);

    // R7 backpressure
    outReady = 1'b0;
    step(8'hA1);
    chk("R7", "outValid", outValid, 1);
    chk("R7", "outByte", outByte, 8'hA1);
    chk("R7", "inReady low", inReady, 0);
    inValid = 1'b1; inByte = 8'hA2;
    repeat (3) @(negedge clk);
    chk("R7", "held byte", outByte, 8'hA1);
    chk("R7", "still valid", outValid, 1);
    chk("R7", "inReady still low", inReady, 0);
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk("R7", "next byte", outByte, 8'hA2);
    chk("R7", "valid", outValid, 1);
    @(negedge clk);
    chk("R7", "drained", outValid, 0);

    // R9 wrap: fresh frame of 256 payload bytes
    doReset();
    step(8'h02);
    begin
      int seen = 0;
      for (int k = 0; k < 256; k++) begin
        step(8'h20);
        if (outValid && outByte == 8'h20) seen++;
      end
      chk("R9", "payload count", seen, 256);
    end
    step(8'h02);
    chk("R9", "no eof at wrapped zero", outEof, 0);
    chk("R9", "still in frame", inFrame, 1);
    step(8'h21);
    chk("R9", "emit after wrap", outByte, 8'h21);
    step(8'h02);
    chk("R9", "eof after wrap", outEof, 1);
    chk("R9", "frame closed", inFrame, 0);
    @(negedge clk);
    chk("R4", "eof one cycle", outEof, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule